// File: doc/BRIEF.md
# Bus Controller Retry and Polling Sequencer

This block is the control state machine of a dual-redundant serial-bus controller. The host writes a chain of message blocks into memory and pulses `go` with the address of the first block. For each block the sequencer reads two words. The first is a control word and the second is a pointer to the next block. It then hands the message to a separate transfer engine through a start/done handshake and waits for the result flags and the returned status word. Word encoding and data movement belong to that engine, not to this block.

When the engine reports a condition that the block has enabled for retry, the message is launched again. The three conditions are a busy terminal, a message error and a response timeout. A retry can use the same bus or the other bus of the pair, and at most four retries are made. When the enabled conditions persist after the last retry, an interrupt pulse reports that the retries are exhausted. In polling mode the status word from the final attempt is compared with a host compare value, and a mismatch raises an interrupt pulse. A block may also request a pause before the next block is fetched. The pause length is a host value in microseconds, and each microsecond is counted as twelve clock cycles. A pointer of zero ends the chain.

Top module: `bc_chain_sequencer`

## Requirements
- R1: After reset `seq_busy`, `xfer_start`, `mem_rd_en`, `irq_exhausted`, `irq_poll_mismatch` and `chain_done` are all 0.
- R2: On `go` the sequencer reads the control word at the block address and the next pointer at block address + 1, with one cycle of read latency. It runs the blocks in linked order, and `xfer_blk` carries the address of the current block. After the block whose pointer is 0x0000 completes, `chain_done` pulses for one cycle and `seq_busy` drops.
- R3: Control bits 0, 1 and 2 separately enable retry on `res_busy`, `res_err` and `res_timeout`. A result flag whose enable is clear causes no retry.
- R4: A message gets at most MAX_RETRY (4) retries, so it has at most 5 attempts.
- R5: The first attempt uses the bus given by control bit 3 (`xfer_bus` 0 = bus A, 1 = bus B). When control bit 4 is set, each retry toggles the bus. When it is clear, every retry stays on the same bus.
- R6: `irq_exhausted` pulses for one cycle, in the cycle after the final `xfer_done`, only when that final attempt still has an enabled retry condition after 4 retries.
- R7: When control bit 5 is set, `irq_poll_mismatch` pulses for one cycle after the final `xfer_done` if `res_timeout` is clear and `res_status` differs from `poll_cmp`. It stays low in every other case.
- R8: After the final `xfer_done` of a block with a non-null pointer, the next `xfer_start` comes 4 cycles later. When control bit 6 is set and `gap_us` is nonzero, it comes 4 + 12·`gap_us` cycles later.
- R9: A retry launches `xfer_start` in the cycle right after the `xfer_done` that triggered it. `xfer_start` is always a single-cycle pulse, and `xfer_bus` is held steady while a result is awaited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go | input | 1 | Start a chain at `head_ptr` (used only when idle) |
| head_ptr | input | AW | Address of the first block |
| gap_us | input | GW | Intermessage pause in microseconds |
| poll_cmp | input | DW | Polling compare value |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | AW | Memory read address |
| mem_rdata | input | DW | Read data, valid one cycle after the request |
| xfer_start | output | 1 | Start pulse to the transfer engine |
| xfer_bus | output | 1 | Bus for this attempt (0 = A, 1 = B) |
| xfer_blk | output | AW | Address of the current block |
| xfer_done | input | 1 | Engine finished the attempt (one cycle) |
| res_busy | input | 1 | Terminal reported busy |
| res_err | input | 1 | Message error detected |
| res_timeout | input | 1 | No response in time |
| res_status | input | DW | Status word returned by the terminal |
| irq_exhausted | output | 1 | Retries exhausted pulse |
| irq_poll_mismatch | output | 1 | Polling compare mismatch pulse |
| chain_done | output | 1 | Chain finished pulse |
| seq_busy | output | 1 | Chain in progress |

## Verification
Directed chains separate the retry cases from one another. One chain has a clean single message. Another gets five busy results in a row with alternate-bus retries, which tells an off-by-one in the retry limit apart from a broken bus toggle. A third returns an error result while only the busy retry is enabled. Polling blocks are fed a matching status word, a mismatching one and a mismatching one with a timeout, which shows that the compare is gated by both the mode bit and the timeout flag. Two-block chains with and without the pause bit measure the exact spacing between `xfer_done` and the next `xfer_start`. Random chains then mix control words, failure flags, engine latencies and pause lengths, and a bench model predicts every attempt's bus, block, spacing and the interrupt counts.

// File: rtl/bcseq_pkg.sv
// Shared types for the chain sequencer.
// Assumes the control word of a block carries its flags in bits 6..0.
package bcseq_pkg;

    // Control word flags, bit 6 down to bit 0.
    typedef struct packed {
        logic gap_en;    // bit 6: pause before next block
        logic poll_en;   // bit 5: compare returned status word
        logic alt_bus;   // bit 4: retries toggle the bus
        logic bus_b;     // bit 3: first attempt on bus B
        logic rty_to;    // bit 2: retry on response timeout
        logic rty_err;   // bit 1: retry on message error
        logic rty_busy;  // bit 0: retry on busy terminal
    } blk_ctl_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CTL,
        ST_NXT,
        ST_LAUNCH,
        ST_WAIT,
        ST_GAP
    } seq_state_t;

endpackage

// File: rtl/bcseq_retry_eval.sv
// Retry decision for one finished attempt.
// Purely combinational. Assumes the result flags are valid while the
// engine's done strobe is high.
module bcseq_retry_eval
    import bcseq_pkg::*;
#(
    parameter int MAX_RETRY = 4,
    parameter int CNT_W     = 3
) (
    input  blk_ctl_t         ctl,
    input  logic             res_busy,
    input  logic             res_err,
    input  logic             res_timeout,
    input  logic [CNT_W-1:0] retry_cnt,
    input  logic             cur_bus,
    output logic             do_retry,
    output logic             exhausted,
    output logic             next_bus
);

    logic cond_hit;
    logic room_left;

    // Find an enabled failure and whether the retry budget allows another attempt.
    always_comb begin
        cond_hit  = (res_busy & ctl.rty_busy) |
                    (res_err & ctl.rty_err) |
                    (res_timeout & ctl.rty_to);
        room_left = (retry_cnt < CNT_W'(MAX_RETRY));
        do_retry  = cond_hit & room_left;
        exhausted = cond_hit & ~room_left;
        next_bus  = ctl.alt_bus ? ~cur_bus : cur_bus;
    end

endmodule

// File: rtl/bcseq_gap_timer.sv
// Intermessage pause timer.
// A divider makes one microsecond tick every TICK_DIV cycles, and a
// down counter of microseconds ends the pause. expire is high in the last
// cycle of a pause lasting us_load*TICK_DIV cycles. Assumes us_load != 0.
module bcseq_gap_timer #(
    parameter int TICK_DIV = 12,
    parameter int GW       = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [GW-1:0] us_load,
    output logic          active,
    output logic          expire
);

    localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [DIV_W-1:0] div_q;
    logic [GW-1:0]    us_q;
    logic             tick;

    // Mark the last cycle of each microsecond and of the whole pause.
    always_comb begin
        tick   = active && (div_q == DIV_W'(TICK_DIV - 1));
        expire = tick && (us_q == GW'(1));
    end

    // Run the cycle divider and the microsecond down counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            div_q  <= '0;
            us_q   <= '0;
        end else if (load) begin
            active <= 1'b1;
            div_q  <= '0;
            us_q   <= us_load;
        end else if (active) begin
            if (tick) begin
                div_q <= '0;
                us_q  <= us_q - GW'(1);
                if (expire) active <= 1'b0;
            end else begin
                div_q <= div_q + DIV_W'(1);
            end
        end
    end

    // A running pause never has an empty microsecond count.
    p_gap_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (us_q != '0));

    // A pause ends in the cycle after expire.
    p_gap_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !load) |=> !active);

endmodule

// File: rtl/bcseq_poll_cmp.sv
// Polling compare for the final attempt of a message.
// Registers a one-cycle mismatch pulse. Assumes eval is high for exactly
// the cycle in which the final result is presented.
module bcseq_poll_cmp #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          eval,
    input  logic          poll_en,
    input  logic          res_timeout,
    input  logic [DW-1:0] status,
    input  logic [DW-1:0] cmp,
    output logic          irq_mismatch
);

    // Raise the mismatch pulse when a polled status word differs from the compare value.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_mismatch <= 1'b0;
        else        irq_mismatch <= eval && poll_en && !res_timeout && (status != cmp);
    end

    // The pulse only follows an evaluated final result.
    p_poll_after_eval_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mismatch |-> $past(eval));

    // The pulse lasts a single cycle.
    p_poll_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mismatch |=> !irq_mismatch);

endmodule

// File: rtl/bc_chain_sequencer.sv
// Linked-list message sequencer for a dual-redundant bus controller.
// Fetches the control word and next pointer of each block, launches the
// transfer engine, retries under control-word rules, checks polled status
// words and inserts optional pauses. Assumes memory reads return data one
// cycle after mem_rd_en and that the engine pulses xfer_done once per start.
module bc_chain_sequencer
    import bcseq_pkg::*;
#(
    parameter int AW        = 16,
    parameter int DW        = 16,
    parameter int GW        = 8,
    parameter int MAX_RETRY = 4,
    parameter int TICK_DIV  = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [AW-1:0] head_ptr,
    input  logic [GW-1:0] gap_us,
    input  logic [DW-1:0] poll_cmp,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    output logic          xfer_start,
    output logic          xfer_bus,
    output logic [AW-1:0] xfer_blk,
    input  logic          xfer_done,
    input  logic          res_busy,
    input  logic          res_err,
    input  logic          res_timeout,
    input  logic [DW-1:0] res_status,
    output logic          irq_exhausted,
    output logic          irq_poll_mismatch,
    output logic          chain_done,
    output logic          seq_busy
);

    localparam int CNT_W = $clog2(MAX_RETRY + 1);
    localparam int CTL_W = $bits(blk_ctl_t);

    seq_state_t       state_q;
    logic [AW-1:0]    ptr_q;
    logic [AW-1:0]    nxt_q;
    blk_ctl_t         ctl_q;
    logic [CNT_W-1:0] retry_cnt_q;
    logic             bus_q;

    logic do_retry;
    logic exhausted;
    logic next_bus;
    logic final_eval;
    logic gap_load;
    logic gap_active;
    logic gap_expire;

    bcseq_retry_eval #(
        .MAX_RETRY (MAX_RETRY),
        .CNT_W     (CNT_W)
    ) u_eval (
        .ctl         (ctl_q),
        .res_busy    (res_busy),
        .res_err     (res_err),
        .res_timeout (res_timeout),
        .retry_cnt   (retry_cnt_q),
        .cur_bus     (bus_q),
        .do_retry    (do_retry),
        .exhausted   (exhausted),
        .next_bus    (next_bus)
    );

    bcseq_gap_timer #(
        .TICK_DIV (TICK_DIV),
        .GW       (GW)
    ) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (gap_load),
        .us_load (gap_us),
        .active  (gap_active),
        .expire  (gap_expire)
    );

    bcseq_poll_cmp #(
        .DW (DW)
    ) u_poll (
        .clk          (clk),
        .rst_n        (rst_n),
        .eval         (final_eval),
        .poll_en      (ctl_q.poll_en),
        .res_timeout  (res_timeout),
        .status       (res_status),
        .cmp          (poll_cmp),
        .irq_mismatch (irq_poll_mismatch)
    );

    // Decode memory requests, engine strobes and timer loading from the state.
    always_comb begin
        mem_rd_en  = (state_q == ST_FETCH) || (state_q == ST_CTL);
        mem_addr   = (state_q == ST_CTL) ? ptr_q + AW'(1) : ptr_q;
        xfer_start = (state_q == ST_LAUNCH);
        xfer_bus   = bus_q;
        xfer_blk   = ptr_q;
        seq_busy   = (state_q != ST_IDLE);
        final_eval = (state_q == ST_WAIT) && xfer_done && !do_retry;
        gap_load   = final_eval && (nxt_q != '0) && ctl_q.gap_en && (gap_us != '0);
    end

    // Main sequencing: fetch, launch, retry, pause, chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= ST_IDLE;
            ptr_q         <= '0;
            nxt_q         <= '0;
            ctl_q         <= '0;
            retry_cnt_q   <= '0;
            bus_q         <= 1'b0;
            irq_exhausted <= 1'b0;
            chain_done    <= 1'b0;
        end else begin
            irq_exhausted <= 1'b0;
            chain_done    <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (go) begin
                        ptr_q   <= head_ptr;
                        state_q <= ST_FETCH;
                    end
                end
                ST_FETCH: state_q <= ST_CTL;
                ST_CTL: begin
                    ctl_q   <= blk_ctl_t'(mem_rdata[CTL_W-1:0]);
                    state_q <= ST_NXT;
                end
                ST_NXT: begin
                    nxt_q       <= mem_rdata[AW-1:0];
                    retry_cnt_q <= '0;
                    bus_q       <= ctl_q.bus_b;
                    state_q     <= ST_LAUNCH;
                end
                ST_LAUNCH: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (xfer_done) begin
                        if (do_retry) begin
                            retry_cnt_q <= retry_cnt_q + CNT_W'(1);
                            bus_q       <= next_bus;
                            state_q     <= ST_LAUNCH;
                        end else begin
                            irq_exhausted <= exhausted;
                            if (nxt_q == '0) begin
                                chain_done <= 1'b1;
                                state_q    <= ST_IDLE;
                            end else if (gap_load) begin
                                state_q <= ST_GAP;
                            end else begin
                                ptr_q   <= nxt_q;
                                state_q <= ST_FETCH;
                            end
                        end
                    end
                end
                ST_GAP: begin
                    if (gap_expire) begin
                        ptr_q   <= nxt_q;
                        state_q <= ST_FETCH;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Start strobes are single-cycle.
    p_start_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start);

    // The bus is held while waiting for a result.
    p_bus_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && $past(state_q) == ST_WAIT) |-> $stable(xfer_bus));

    // The retry counter never passes its limit.
    p_retry_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |-> (retry_cnt_q <= CNT_W'(MAX_RETRY)));

    // Exhaustion is reported only right after a finished attempt.
    p_exh_after_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_exhausted |-> $past(xfer_done));

    // The pause state and the timer agree.
    p_gap_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP) |-> gap_active);

    // The end-of-chain pulse leaves the sequencer idle.
    p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        chain_done |-> !seq_busy);

endmodule

// File: tb/bc_chain_sequencer_tb_top.sv
module bc_chain_sequencer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go = 1'b0;
    logic [15:0] head_ptr = '0;
    logic [7:0]  gap_us = '0;
    logic [15:0] poll_cmp = '0;
    logic        mem_rd_en;
    logic [15:0] mem_addr;
    logic [15:0] mem_rdata = '0;
    logic        xfer_start;
    logic        xfer_bus;
    logic [15:0] xfer_blk;
    logic        xfer_done = 1'b0;
    logic        res_busy = 1'b0;
    logic        res_err = 1'b0;
    logic        res_timeout = 1'b0;
    logic [15:0] res_status = '0;
    logic        irq_exhausted;
    logic        irq_poll_mismatch;
    logic        chain_done;
    logic        seq_busy;

    bc_chain_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .go(go), .head_ptr(head_ptr), .gap_us(gap_us),
        .poll_cmp(poll_cmp), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .xfer_start(xfer_start), .xfer_bus(xfer_bus),
        .xfer_blk(xfer_blk), .xfer_done(xfer_done), .res_busy(res_busy),
        .res_err(res_err), .res_timeout(res_timeout), .res_status(res_status),
        .irq_exhausted(irq_exhausted), .irq_poll_mismatch(irq_poll_mismatch),
        .chain_done(chain_done), .seq_busy(seq_busy)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [15:0] mem [0:255];
    logic [15:0] rd_pend = '0;
    logic [6:0]  ctls [0:7];
    logic        rb [0:63];
    logic        re [0:63];
    logic        rt [0:63];
    logic [15:0] rs [0:63];

    int          start_cyc [0:63];
    int          done_cyc  [0:63];
    logic        start_bus [0:63];
    logic [15:0] start_blk [0:63];
    int n_start = 0, n_exh = 0, n_poll = 0, n_done = 0, eng_k = 0, eng_cnt = 0;

    logic        exp_bus [0:63];
    logic [15:0] exp_blk [0:63];
    int          exp_gap [0:63];
    int exp_n, exp_exh, exp_poll;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic logic [15:0] blk_addr(input int i);
        return 16'(8 + 8 * i);
    endfunction

    // Memory with one cycle latency, engine model and output monitor.
    initial begin
        forever begin
            @(negedge clk);
            mem_rdata = rd_pend;
            if (mem_rd_en) rd_pend = mem[mem_addr[7:0]];
            if (xfer_done) begin
                xfer_done = 1'b0;
                eng_k++;
            end
            if (irq_exhausted) n_exh++;
            if (irq_poll_mismatch) n_poll++;
            if (chain_done) n_done++;
            if (xfer_start) begin
                if (n_start < 64) begin
                    start_cyc[n_start] = cyc;
                    start_bus[n_start] = xfer_bus;
                    start_blk[n_start] = xfer_blk;
                end
                n_start++;
                eng_cnt = 1 + int'($urandom % 3);
            end else if (eng_cnt > 0) begin
                eng_cnt--;
                if (eng_cnt == 0) begin
                    xfer_done   = 1'b1;
                    res_busy    = rb[eng_k & 63];
                    res_err     = re[eng_k & 63];
                    res_timeout = rt[eng_k & 63];
                    res_status  = rs[eng_k & 63];
                    done_cyc[eng_k & 63] = cyc;
                end
            end
        end
    end

    // Bench model of retries, bus steering, polling and spacing.
    task automatic predict(input int n);
        int g = 0;
        exp_exh = 0;
        exp_poll = 0;
        for (int i = 0; i < n; i++) begin
            logic [6:0] c = ctls[i];
            logic bus = c[3];
            int r = 0;
            bit fin = 0;
            while (!fin) begin
                bit hit = (rb[g] & c[0]) | (re[g] & c[1]) | (rt[g] & c[2]);
                exp_bus[g] = bus;
                exp_blk[g] = blk_addr(i);
                if (hit && r < 4) begin
                    exp_gap[g] = 1;
                    r++;
                    if (c[4]) bus = ~bus;
                end else begin
                    if (hit) exp_exh++;
                    if (c[5] && !rt[g] && rs[g] != poll_cmp) exp_poll++;
                    exp_gap[g] = 4 + ((c[6] && gap_us != 0) ? 12 * int'(gap_us) : 0);
                    fin = 1;
                end
                g++;
            end
        end
        exp_n = g;
    endtask

    task automatic run_chain(input int n, input string tag);
        int t = 0;
        for (int i = 0; i < n; i++) begin
            mem[blk_addr(i)]       = {9'd0, ctls[i]};
            mem[blk_addr(i) + 1]   = (i == n - 1) ? 16'h0000 : blk_addr(i + 1);
        end
        predict(n);
        n_start = 0; n_exh = 0; n_poll = 0; n_done = 0; eng_k = 0;
        head_ptr = blk_addr(0);
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        while (n_done == 0 && t < 5000) begin
            @(negedge clk);
            t++;
        end
        chk(!seq_busy, {tag, " R2 idle after chain"}, int'(seq_busy), 0);
        @(negedge clk);
        chk(n_done == 1, {tag, " R2 chain_done pulses"}, n_done, 1);
        chk(n_start == exp_n, {tag, " R4 attempt count"}, n_start, exp_n);
        chk(n_exh == exp_exh, {tag, " R6 exhausted irqs"}, n_exh, exp_exh);
        chk(n_poll == exp_poll, {tag, " R7 poll mismatch irqs"}, n_poll, exp_poll);
        for (int a = 0; a < exp_n && a < n_start && a < 64; a++) begin
            chk(start_bus[a] == exp_bus[a], {tag, " R5 bus per attempt"},
                int'(start_bus[a]), int'(exp_bus[a]));
            chk(start_blk[a] == exp_blk[a], {tag, " R2 block order"},
                int'(start_blk[a]), int'(exp_blk[a]));
            if (a + 1 < exp_n && a + 1 < n_start)
                chk(start_cyc[a + 1] - done_cyc[a] == exp_gap[a],
                    {tag, (exp_gap[a] == 1) ? " R9 retry spacing" : " R8 next start spacing"},
                    start_cyc[a + 1] - done_cyc[a], exp_gap[a]);
        end
    endtask

    task automatic clear_resp();
        for (int k = 0; k < 64; k++) begin
            rb[k] = 0; re[k] = 0; rt[k] = 0; rs[k] = poll_cmp;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        for (int k = 0; k < 256; k++) mem[k] = '0;
        repeat (3) @(negedge clk);
        chk(!seq_busy && !xfer_start && !mem_rd_en && !irq_exhausted &&
            !irq_poll_mismatch && !chain_done, "R1 reset outputs", 1, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!seq_busy, "R1 idle after reset", int'(seq_busy), 0);

        // Clean single message on bus A.
        poll_cmp = 16'h0800; gap_us = 0;
        clear_resp();
        ctls[0] = 7'b0000111;
        run_chain(1, "clean");

        // Five busy results, alternate bus, start on B: exhaustion.
        clear_resp();
        for (int k = 0; k < 5; k++) rb[k] = 1;
        ctls[0] = 7'b0011001;
        run_chain(1, "exhaust R3");

        // Error result but only the busy retry is enabled: no retry, no irq.
        clear_resp();
        re[0] = 1;
        ctls[0] = 7'b0000001;
        run_chain(1, "disabled R3");

        // Retry on same bus, recovers on the third attempt.
        clear_resp();
        rt[0] = 1; rt[1] = 1;
        ctls[0] = 7'b0001100;
        run_chain(1, "same bus R5");

        // Polling: match, mismatch, mismatch hidden by timeout.
        clear_resp();
        rs[1] = 16'h0801; rs[2] = 16'h0001; rt[2] = 1;
        ctls[0] = 7'b0100000; ctls[1] = 7'b0100000; ctls[2] = 7'b0100000;
        run_chain(3, "poll R7");

        // Pause enabled with 3 us, then disabled.
        clear_resp();
        gap_us = 8'd3;
        ctls[0] = 7'b1000000; ctls[1] = 7'b0000000; ctls[2] = 7'b0000000;
        run_chain(3, "gap R8");

        // Random chains.
        for (int t = 0; t < 14; t++) begin
            int n = 1 + int'($urandom % 4);
            poll_cmp = 16'($urandom);
            gap_us = 8'($urandom % 3);
            for (int i = 0; i < n; i++) ctls[i] = 7'($urandom);
            for (int k = 0; k < 64; k++) begin
                rb[k] = ($urandom % 4) == 0;
                re[k] = ($urandom % 4) == 0;
                rt[k] = ($urandom % 4) == 0;
                rs[k] = ($urandom % 2) ? poll_cmp : poll_cmp ^ (16'h1 << ($urandom % 16));
            end
            if (t == 0) for (int k = 0; k < 6; k++) begin
                rb[k] = 1; re[k] = 1; rt[k] = 1;
            end
            run_chain(n, "random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule